// File: doc/BRIEF.md
# Unsigned integer to single precision exception flag unit

This execution unit predicts the IEEE exception flags that converting a 32-bit unsigned integer to single precision, rounded toward zero, would raise. It never forms the converted value. It returns a 32-bit flag word laid out like the processor's status exception field. The only flag this conversion can raise is inexact. Inexact is set when the operand carries more significant bits than the 24-bit significand can hold, and a discarded bit is nonzero.

Operations issue with a valid strobe, the operand, the least significant bit of the guard register and a destination tag. The guard bit and the tag go down a three-stage pipeline with the data. Stage 1 finds the leading one. Stage 2 builds the mask of the bits that would be discarded. Stage 3 OR-reduces the masked bits and applies the guard. A writeback strobe is raised only for guarded-true operations. The unit ignores any global rounding mode and never touches global status. A new operation can issue every cycle.

Top module: `u2f_exc_unit`

## Requirements
- R1: When the operand's leading one is at bit 24 or higher, flag bit 1 (inexact, value 0x02) is 1 exactly when at least one bit below the 24 bits starting at the leading one is 1. Examples: 0xFFFFFFFF, 0xFFFFFFFD, 0x7FFFFFFF, 0x7FFFFFF1 and 0x01FFFFFF give 0x02; 0x80000000 and 0x01FFFFFE give 0.
- R2: An operand whose leading one is at bit 23 or lower, including 0, 3 and 0x00FFFFFF, gives a flag word of 0x00000000.
- R3: Every flag word bit other than bit 1 is always 0. This covers divide-by-zero (bit 0), underflow (2), overflow (3), invalid (4), input flushed (5), output flushed (6) and bits 7 to 31.
- R4: `out_vld` is 1 exactly three clock edges after an issue that had `in_vld`=1 and `in_guard`=1. An issue with `in_guard`=0 produces no writeback.
- R5: Operations may issue on consecutive cycles, and each writeback carries the `in_tag` of its own operation, three edges after issue.
- R6: Synchronous active-high reset discards all in-flight operations. `out_vld` is 0 while reset is high and for the first three edges after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Issue strobe |
| in_opnd | input | 32 | Unsigned integer operand |
| in_guard | input | 1 | Least significant bit of the guard register |
| in_tag | input | 5 | Destination register tag |
| out_vld | output | 1 | Writeback strobe |
| out_tag | output | 5 | Destination tag of the writeback |
| out_flags | output | 32 | Exception flag word |

## Verification
Every result is due exactly three rising edges after its issue: the strobe, the tag and the flag word all appear together. The bench drives inputs on falling edges and checks on falling edges. At each falling edge it compares the outputs with the expectation recorded three steps earlier, held in a short history ring. When a reset pulse is applied, the bench clears the expectations for operations still in flight, so that their absent writebacks are expected.

// File: rtl/u2f_exc_pkg.sv
package u2f_exc_pkg;
  // Bit positions of the exception flag word
  localparam int FLG_DZ  = 0;
  localparam int FLG_INX = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_OVF = 3;
  localparam int FLG_INV = 4;
  localparam int FLG_IFZ = 5;
  localparam int FLG_OFZ = 6;
endpackage

// File: rtl/u2f_lead_find.sv
module u2f_lead_find #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic              in_guard,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              s1_vld,
  output logic [DATA_W-1:0] s1_opnd,
  output logic [POS_W-1:0]  s1_lead,
  output logic              s1_guard,
  output logic [TAG_W-1:0]  s1_tag
);
  logic [POS_W-1:0] lead_c;

  // Highest set bit wins; zero operand yields position 0 (no bits discarded)
  always_comb begin
    lead_c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (in_opnd[i]) lead_c = POS_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    s1_opnd  <= in_opnd;
    s1_lead  <= lead_c;
    s1_guard <= in_guard;
    s1_tag   <= in_tag;
  end
endmodule

// File: rtl/u2f_drop_mask.sv
module u2f_drop_mask #(
  parameter int DATA_W = 32,
  parameter int MANT_W = 24,
  parameter int TAG_W  = 5,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_vld,
  input  logic [DATA_W-1:0] s1_opnd,
  input  logic [POS_W-1:0]  s1_lead,
  input  logic              s1_guard,
  input  logic [TAG_W-1:0]  s1_tag,
  output logic              s2_vld,
  output logic [DATA_W-1:0] s2_opnd,
  output logic [DATA_W-1:0] s2_mask,
  output logic              s2_guard,
  output logic [TAG_W-1:0]  s2_tag
);
  logic [DATA_W-1:0] mask_c;

  // Bit i is lost when it sits MANT_W or more places below the leading one
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask_c[i] = (32'(s1_lead) >= 32'(i + MANT_W));
  end

  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else     s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    s2_opnd  <= s1_opnd;
    s2_mask  <= mask_c;
    s2_guard <= s1_guard;
    s2_tag   <= s1_tag;
  end
endmodule

// File: rtl/u2f_flag_pack.sv
module u2f_flag_pack
  import u2f_exc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s2_vld,
  input  logic [DATA_W-1:0] s2_opnd,
  input  logic [DATA_W-1:0] s2_mask,
  input  logic              s2_guard,
  input  logic [TAG_W-1:0]  s2_tag,
  output logic              out_vld,
  output logic [TAG_W-1:0]  out_tag,
  output logic [FLAG_W-1:0] out_flags
);
  logic [FLAG_W-1:0] flags_c;

  // Only inexact can occur for an unsigned integer to single conversion
  always_comb begin
    flags_c          = '0;
    flags_c[FLG_INX] = |(s2_opnd & s2_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= s2_vld & s2_guard;
  end

  always_ff @(posedge clk) begin
    out_tag   <= s2_tag;
    out_flags <= flags_c;
  end
endmodule

// File: rtl/u2f_exc_unit.sv
module u2f_exc_unit #(
  parameter int DATA_W = 32,
  parameter int MANT_W = 24,
  parameter int FLAG_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_opnd,
  input  logic              in_guard,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_vld,
  output logic [TAG_W-1:0]  out_tag,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int POS_W = $clog2(DATA_W);

  logic              s1_vld, s1_guard;
  logic [DATA_W-1:0] s1_opnd;
  logic [POS_W-1:0]  s1_lead;
  logic [TAG_W-1:0]  s1_tag;
  logic              s2_vld, s2_guard;
  logic [DATA_W-1:0] s2_opnd, s2_mask;
  logic [TAG_W-1:0]  s2_tag;

  u2f_lead_find #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_st1 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_opnd(in_opnd),
    .in_guard(in_guard), .in_tag(in_tag), .s1_vld(s1_vld),
    .s1_opnd(s1_opnd), .s1_lead(s1_lead), .s1_guard(s1_guard),
    .s1_tag(s1_tag)
  );

  u2f_drop_mask #(.DATA_W(DATA_W), .MANT_W(MANT_W), .TAG_W(TAG_W)) i_st2 (
    .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_opnd(s1_opnd),
    .s1_lead(s1_lead), .s1_guard(s1_guard), .s1_tag(s1_tag),
    .s2_vld(s2_vld), .s2_opnd(s2_opnd), .s2_mask(s2_mask),
    .s2_guard(s2_guard), .s2_tag(s2_tag)
  );

  u2f_flag_pack #(.DATA_W(DATA_W), .FLAG_W(FLAG_W), .TAG_W(TAG_W)) i_st3 (
    .clk(clk), .rst(rst), .s2_vld(s2_vld), .s2_opnd(s2_opnd),
    .s2_mask(s2_mask), .s2_guard(s2_guard), .s2_tag(s2_tag),
    .out_vld(out_vld), .out_tag(out_tag), .out_flags(out_flags)
  );
endmodule

// File: rtl/u2f_exc_chk.sv
module u2f_exc_chk
  import u2f_exc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MANT_W = 24,
  parameter int FLAG_W = 32,
  parameter int TAG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_opnd,
  input logic              in_guard,
  input logic [TAG_W-1:0]  in_tag,
  input logic              out_vld,
  input logic [TAG_W-1:0]  out_tag,
  input logic [FLAG_W-1:0] out_flags
);
  // Edges since reset release, saturating at the pipeline depth
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !out_vld);

  assert_writeback_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_vld == $past(in_vld && in_guard, 3)));

  assert_tag_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_vld) |-> (out_tag == $past(in_tag, 3)));

  assert_only_inexact_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> ((out_flags & ~(FLAG_W'(1) << FLG_INX)) == '0));

  assert_top_bit_inexact_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_opnd[DATA_W-1], 3)) |->
      (out_flags[FLG_INX] == $past(|in_opnd[DATA_W-MANT_W-1:0], 3)));

  assert_small_exact_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(in_opnd[DATA_W-1:MANT_W] == '0, 3)) |->
      (out_flags == '0));
endmodule

bind u2f_exc_unit u2f_exc_chk #(
  .DATA_W(DATA_W), .MANT_W(MANT_W), .FLAG_W(FLAG_W), .TAG_W(TAG_W)
) i_chk (.*);

// File: tb/test_u2f_exc_unit.sv
`timescale 1ns/1ps
module test_u2f_exc_unit;
  localparam int DW = 32;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_opnd = '0;
  logic          in_guard = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic          out_vld;
  logic [TW-1:0] out_tag;
  logic [31:0]   out_flags;

  int errors = 0;
  int checks = 0;
  int n = 0;
  bit done = 0;

  logic          hv [8];
  logic [TW-1:0] ht [8];
  logic [31:0]   hf [8];
  logic          hr [8];

  u2f_exc_unit i_u2f_exc_unit (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_opnd(in_opnd),
    .in_guard(in_guard), .in_tag(in_tag), .out_vld(out_vld),
    .out_tag(out_tag), .out_flags(out_flags)
  );

  always #4 clk = ~clk;

  // Reference: shift right until the value fits 24 bits, noting lost ones
  function automatic logic [31:0] ref_flags(logic [31:0] v);
    logic [31:0] t = v;
    logic lost = 1'b0;
    while (t >= 32'h0100_0000) begin
      lost = lost | t[0];
      t = t >> 1;
    end
    return lost ? 32'h0000_0002 : 32'h0;
  endfunction

  task automatic verify();
    int k = (n + 5) % 8;
    checks++;
    if (out_vld !== hv[k]) begin
      errors++;
      $display("FAIL %s out_vld=%0b expected %0b at step %0d",
               hr[k] ? "R6" : "R4", out_vld, hv[k], n);
    end
    if (hv[k]) begin
      checks++;
      if (out_tag !== ht[k]) begin
        errors++;
        $display("FAIL R5 tag=%0h expected %0h", out_tag, ht[k]);
      end
      checks++;
      if ((out_flags & 32'hFFFF_FFFD) !== 32'h0) begin
        errors++;
        $display("FAIL R3 flags=%08h expected %08h", out_flags, hf[k]);
      end
      checks++;
      if (out_flags !== hf[k]) begin
        errors++;
        $display("FAIL %s flags=%08h expected %08h",
                 hf[k] != 0 ? "R1" : "R2", out_flags, hf[k]);
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [31:0] d,
                      input logic g, input logic [TW-1:0] t);
    @(negedge clk);
    verify();
    if (r && !rst) begin
      hv[(n + 7) % 8] = 1'b0; hr[(n + 7) % 8] = 1'b1;
      hv[(n + 6) % 8] = 1'b0; hr[(n + 6) % 8] = 1'b1;
    end
    hv[n % 8] = v && g && !r;
    hr[n % 8] = r;
    ht[n % 8] = t;
    hf[n % 8] = ref_flags(d);
    rst = r; in_vld = v; in_opnd = d; in_guard = g; in_tag = t;
    n++;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 8; i++) begin hv[i] = 0; ht[i] = 0; hf[i] = 0; hr[i] = 1; end
    repeat (2) @(posedge clk);
    // R6: valid issues during reset must never write back
    for (int i = 0; i < 3; i++) step(1, 1, 32'hFFFF_FFFF, 1, 5'(i));
    // Directed corner cases (R1, R2, R4)
    step(0, 1, 32'h0000_0003, 1, 5'd1);
    step(0, 1, 32'hFFFF_FFFF, 1, 5'd2);
    step(0, 1, 32'hFFFF_FFFD, 0, 5'd3);
    step(0, 1, 32'hFFFF_FFFD, 1, 5'd4);
    step(0, 1, 32'h7FFF_FFFF, 1, 5'd5);
    step(0, 1, 32'h8000_0000, 1, 5'd6);
    step(0, 1, 32'h7FFF_FFF1, 1, 5'd7);
    step(0, 1, 32'h0000_0000, 1, 5'd8);
    step(0, 1, 32'h00FF_FFFF, 1, 5'd9);
    step(0, 1, 32'h01FF_FFFF, 1, 5'd10);
    step(0, 1, 32'h01FF_FFFE, 1, 5'd11);
    step(0, 0, 32'hFFFF_FFFF, 1, 5'd12);
    // Random back-to-back traffic (R5) with a reset pulse in the middle (R6)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d = $urandom >> ($urandom % 33);
      if ($urandom % 4 == 0) d = d & 32'hFFFF_FF00;
      step((i >= 1500 && i < 1503), ($urandom % 5) != 0, d,
           1'($urandom), 5'($urandom));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 32'h0, 0, 5'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule